// File: doc/BRIEF.md
# Programmable I/O Clock Divider

This block derives a slower clock for an I/O bus from the main bus clock. A three-bit rate field selects the ratio: the even codes select divide-by-8, 2, 4 or 6, and every odd code selects a pass-through mode. In pass-through mode the divided output holds at a constant logic 1. Devices that need a clock at full rate are then wired to the bus clock directly.

The rate field sits in an 8-bit control register. The register is reached through a small on-chip register port with an address, write data, a write strobe, a read strobe and read data. The upper five bits are reserved and are not stored. The divided clock is a register output timed by the bus clock. A new rate is adopted only at the start of a divided period, so a ratio change never produces a shortened pulse. The current register value is also driven on a dedicated output.

Top module: `ioclk_divider_top`

## Requirements
- R1: A write strobe with address 03h stores write-data bits [2:0] as the rate field on the next clock edge. Bits [7:3] are discarded, so the register value always has bits [7:3] equal to 0.
- R2: When the read strobe is high and the address is 03h, read data in the same cycle equals {5'b0, rate}. In every other cycle read data is 0.
- R3: A write strobe with any address other than 03h leaves the register value unchanged.
- R4: After reset the register is 00h and the divided clock is high. With no writes it is high for 4 bus cycles and then low for 4 bus cycles, repeating.
- R5: Rate codes 000, 010, 100 and 110 give periods of 8, 2, 4 and 6 bus cycles. Each period is high for its first half and low for its second half.
- R6: Any rate code with bit 0 set (001, 011, 101, 111) holds the divided clock at constant 1.
- R7: A new rate code is adopted only when a divided period ends: after the last low cycle of an even ratio, or after any cycle in constant-1 mode. The period that is running when the code changes completes with its old ratio.
- R8: The register-value output always equals {5'b0, rate} as currently stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Register port write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational |
| io_clk | output | 1 | Divided I/O clock, registered |
| ctrl_value | output | 8 | Current control register value |

## Verification
The assertions take for granted that the strobes, the address and the write data are stable and known around each rising edge. They also assume that the reset is held long enough to clear every register. No assumption limits how often the rate may change: writes may arrive in any cycle of a divided period, including the last one. The stimulus changes inputs only on falling edges. It mixes writes to the control address with writes to random other addresses, including odd codes and values with reserved bits set. It also includes directed changes placed in the middle of a period and at its end.

// File: rtl/ioclk_pkg.sv
package ioclk_pkg;
    localparam int RATE_W = 3;
    localparam int HALF_W = 3;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] cnt;
        logic              clk_out;
    } div_state_t;

    // Half-period in bus cycles; 0 marks the constant-high mode.
    function automatic logic [HALF_W-1:0] half_of(input logic [RATE_W-1:0] code);
        logic [HALF_W-1:0] h;
        if (code[0])
            h = '0;
        else if (code[RATE_W-1:1] == '0)
            h = HALF_W'(4);
        else
            h = HALF_W'(code[RATE_W-1:1]);
        return h;
    endfunction
endpackage

// File: rtl/ioclk_ctrl_reg.sv
module ioclk_ctrl_reg #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int RATE_W   = 3,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic [RATE_W-1:0] rate
);
    localparam int PAD_W = DATA_W - RATE_W;

    logic [RATE_W-1:0] rate_d, rate_q;
    logic              hit;
    logic              unused_hi;

    assign hit       = (addr == REG_ADDR);
    assign unused_hi = ^wdata[DATA_W-1:RATE_W];

    always_comb begin
        rate_d = rate_q;
        if (wr && hit)
            rate_d = wdata[RATE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rate_q <= '0;
        else
            rate_q <= rate_d;
    end

    assign rate  = rate_q;
    assign rdata = (rd && hit) ? {{PAD_W{1'b0}}, rate_q} : '0;
endmodule

// File: rtl/ioclk_div_core.sv
module ioclk_div_core
    import ioclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              clk_out
);
    div_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.half == '0) begin
            // constant-high mode: every cycle is a period boundary
            s_d.half    = half_of(rate);
            s_d.cnt     = '0;
            s_d.clk_out = 1'b1;
        end else if (s_q.cnt == s_q.half - HALF_W'(1)) begin
            s_d.cnt = '0;
            if (!s_q.clk_out) begin
                s_d.clk_out = 1'b1;
                s_d.half    = half_of(rate);
            end else begin
                s_d.clk_out = 1'b0;
            end
        end else begin
            s_d.cnt = s_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.half    <= half_of('0);
            s_q.cnt     <= '0;
            s_q.clk_out <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_out = s_q.clk_out;
endmodule

// File: rtl/ioclk_divider_top.sv
module ioclk_divider_top
    import ioclk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              io_clk,
    output logic [DATA_W-1:0] ctrl_value
);
    logic [RATE_W-1:0] rate;

    ioclk_ctrl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W), .REG_ADDR(REG_ADDR)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata), .rate(rate)
    );

    ioclk_div_core u_div (
        .clk(clk), .rst_n(rst_n), .rate(rate), .clk_out(io_clk)
    );

    assign ctrl_value = {{(DATA_W-RATE_W){1'b0}}, rate};
endmodule

// File: rtl/ioclk_divider_chk.sv
module ioclk_divider_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h03
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              io_clk,
    input logic [DATA_W-1:0] ctrl_value
);
    localparam int MAX_HALF = 4;

    logic [3:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (io_clk)
            low_run <= '0;
        else if (low_run != 4'hF)
            low_run <= low_run + 4'd1;
    end

    assert_write_stores_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ADDR) |=> ctrl_value == {5'b0, $past(reg_wdata[2:0])});

    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == REG_ADDR) |-> reg_rdata == '0);

    assert_read_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_ADDR) |-> reg_rdata == ctrl_value);

    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr != REG_ADDR) |=> $stable(ctrl_value));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_value[DATA_W-1:3] == '0);

    assert_low_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 4'(MAX_HALF));
endmodule

bind ioclk_divider_top ioclk_divider_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .io_clk(io_clk), .ctrl_value(ctrl_value)
);

// File: tb/ioclk_divider_top_test.sv
module ioclk_divider_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       io_clk;
    logic [7:0] ctrl_value;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    ioclk_divider_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .io_clk(io_clk), .ctrl_value(ctrl_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input logic [2:0] code);
        case (code)
            3'b000: return 8;
            3'b010: return 2;
            3'b100: return 4;
            3'b110: return 6;
            default: return 1;
        endcase
    endfunction

    // reference model: position within the running period
    logic [2:0] m_reg;
    int         m_per;
    int         m_pos;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg <= '0; m_per <= 8; m_pos <= 0;
        end else begin
            if (reg_wr && reg_addr == 8'h03) m_reg <= reg_wdata[2:0];
            if (m_pos + 1 >= m_per) begin
                m_pos <= 0; m_per <= period_of(m_reg);
            end else begin
                m_pos <= m_pos + 1;
            end
        end
    end

    function automatic logic exp_clk(input int per, input int pos);
        return (per == 1) ? 1'b1 : (pos < per / 2);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string clk_tag);
        string t;
        t = (m_per == 1) ? "R6" : clk_tag;
        check(t, {7'b0, io_clk}, {7'b0, exp_clk(m_per, m_pos)});
        check("R8", ctrl_value, {5'b0, m_reg});
        check("R2", reg_rdata, (reg_rd && reg_addr == 8'h03) ? {5'b0, m_reg} : 8'h00);
    endtask

    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [7:0] d, input string tag);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        #1 compare_all(tag);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) #1;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4", ctrl_value, 8'h00);
        check("R4", {7'b0, io_clk}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "R4");
        // R1: reserved bits dropped; R2: read back
        step(1'b1, 1'b0, 8'h03, 8'hFC, "R1");
        step(1'b0, 1'b1, 8'h03, 8'h00, "R1");
        check("R1", ctrl_value, 8'h04);
        // R3: write elsewhere
        step(1'b1, 1'b0, 8'h13, 8'h03, "R3");
        step(1'b0, 1'b1, 8'h03, 8'h00, "R3");
        check("R3", ctrl_value, 8'h04);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "R5");
        // R7: change mid-period, old period completes
        step(1'b1, 1'b0, 8'h03, 8'h02, "R7");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "R7");
        // R6: odd codes, then back to an even ratio
        step(1'b1, 1'b0, 8'h03, 8'h05, "R6");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "R6");
        step(1'b1, 1'b0, 8'h03, 8'h06, "R7");
        for (int i = 0; i < 14; i++) step(1'b0, 1'b0, 8'h00, 8'h00, "R5");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic       w;
            logic [7:0] a;
            w = ($urandom % 25) == 0;
            a = ($urandom % 3 == 0) ? 8'($urandom) : 8'h03;
            step(w, 1'($urandom), a, 8'($urandom), "R5");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule